// File: doc/BRIEF.md
# Dual-Bank Microcode Sequencer

This block steps through a small program store and drives a modular arithmetic unit on behalf of an elliptic-curve point engine. Operands sit in two register banks, LO and HI, each indexed by a 6-bit operand address. Each instruction does one of the following:

- copies an operand across banks;
- launches a modular add, subtract or multiply, reading both sources from one bank and writing the result into a chosen bank;
- tests an operand for zero, which updates one of two dedicated flags;
- opens or closes a counted hardware loop.

Two calc variants run only on odd or only on even passes of the loop. This lets a ladder-style body alternate its work without branching.

The arithmetic unit in this project is a behavioural stub. It has a fixed latency and a reduced word width. The sequencer waits for its done pulse before it fetches again. The program store is written through a load port while the sequencer is idle. The banks are preloaded and read back through a host port. A start pulse runs the program from address 0. A halt instruction ends the run and raises `ready`.

Top module: `useq_top`

## Requirements
- R1: Instruction word, 34 bits, MSB first: [33:30] opcode, [29:28] math (0 ADD, 1 SUB, 2 MUL), [27] source bank, [26] destination bank (0 = LO, 1 = HI), [25:20] first address A, [19:14] second address B, [13:8] destination address D, [7:0] loop count. Opcodes: 0 HALT, 1 MOVE, 2 CALC, 3 CALC_ODD, 4 CALC_EVEN, 5 ZTEST, 6 LOOP, 7 ENDLOOP.
- R2: After reset `ready` is 1, both zero flags are 0, every entry of both banks reads 0, and nothing executes until `start`.
- R3: A `start` pulse sets the program counter to 0 and clears the loop count and the pass parity. It drops `ready` one cycle later. It leaves both zero flags unchanged.
- R4: MOVE (opcode 1) copies entry A of the source bank into entry D of the other bank, whatever the destination-bank bit says. It takes one cycle.
- R5: CALC with math 0/1/2 writes (x+y) mod M, (x−y) mod M or (x·y) mod M. Here x = entry A and y = entry B of the source bank, M is the MODULUS parameter (65521 by default), and both operands are below M.
- R6: A CALC result lands in entry D of the destination bank, which may equal the source bank. From issue to writeback it takes 1+LAT cycles, where LAT is the stub latency (3 by default), and the program counter holds until the done pulse.
- R7: ZTEST (opcode 5) sets the R0-Z flag to (entry A == 0) when A is 7. It sets the R1-Z flag the same way when A is 10. For any other A both flags keep their value. It takes one cycle.
- R8: LOOP (opcode 6) with count N runs the instructions up to the matching ENDLOOP (opcode 7) N times, or once when N is 0. ENDLOOP either branches back to the instruction after LOOP or falls through. LOOP and ENDLOOP each take one cycle.
- R9: Passes through the loop are numbered from 0. CALC_ODD (opcode 3) executes only on odd passes and CALC_EVEN (opcode 4) only on even passes. Outside any loop since `start`, the pass counts as even.
- R10: A skipped conditional calc takes one cycle, issues no arithmetic request and writes no bank entry.
- R11: HALT (opcode 0) sets `ready` one cycle after it is fetched. `ready` stays high and the program counter stays still until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Restart the program at address 0 |
| prog_we | input | 1 | Program store write enable |
| prog_addr | input | 5 | Program store write address |
| prog_data | input | 34 | Instruction word to store |
| host_we | input | 1 | Operand bank write enable (only while idle) |
| host_bank | input | 1 | Bank selected for host read and write (0 LO, 1 HI) |
| host_addr | input | 6 | Operand address for host read and write |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Combinational read of the addressed bank entry |
| ready | output | 1 | High while the sequencer is halted |
| flag_r0z | output | 1 | Zero flag of the R0-Z test |
| flag_r1z | output | 1 | Zero flag of the R1-Z test |

## Verification
Every program ends in HALT, so each result is due a known number of clock edges after the start edge. That count is the sum of the instruction costs: one cycle for MOVE, ZTEST, LOOP, ENDLOOP, a skipped conditional and HALT, and 1+LAT cycles for an executed calc. The bench counts edges from the start edge until `ready` is seen high and compares the count with that sum. It reads bank entries and flags only once `ready` has risen. Flag preservation across `start` is sampled in the half cycle after the start edge, before the first instruction can execute.

// File: rtl/useq_pkg.sv
package useq_pkg;

   // operand address and loop count widths
   localparam int AW = 6;
   localparam int CW = 8;

   typedef enum logic [3:0] {
      OPC_HALT      = 4'd0,
      OPC_MOVE      = 4'd1,
      OPC_CALC      = 4'd2,
      OPC_CALC_ODD  = 4'd3,
      OPC_CALC_EVEN = 4'd4,
      OPC_ZTEST     = 4'd5,
      OPC_LOOP      = 4'd6,
      OPC_ENDLOOP   = 4'd7
   } opc_e;

   typedef enum logic [1:0] {
      MATH_ADD = 2'd0,
      MATH_SUB = 2'd1,
      MATH_MUL = 2'd2
   } math_e;

   typedef struct packed {
      opc_e            opc;
      math_e           math;
      logic            sb;
      logic            db;
      logic [AW-1:0]   a1;
      logic [AW-1:0]   a2;
      logic [AW-1:0]   ad;
      logic [CW-1:0]   cnt;
   } uinstr_t;

   localparam int UI_W = $bits(uinstr_t);

   // operand addresses whose zero tests feed the two flags
   localparam logic [AW-1:0] ADDR_R0Z = AW'(7);
   localparam logic [AW-1:0] ADDR_R1Z = AW'(10);

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_WAIT = 2'd2
   } seq_state_e;

endpackage

// File: rtl/useq_bank.sv
module useq_bank #(
   parameter int WORD_W  = 16,
   parameter int NUM_OPS = 38,
   parameter int AW      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     wa,
   input  logic [WORD_W-1:0] wd,
   input  logic [AW-1:0]     ra1,
   input  logic [AW-1:0]     ra2,
   input  logic [AW-1:0]     ra3,
   output logic [WORD_W-1:0] rd1,
   output logic [WORD_W-1:0] rd2,
   output logic [WORD_W-1:0] rd3
);

   generate
      if (NUM_OPS > (1 << AW)) begin : g_bad_depth
         $error("useq_bank: NUM_OPS exceeds the address space");
      end
      if (WORD_W < 2) begin : g_bad_width
         $error("useq_bank: WORD_W too small");
      end
   endgenerate

   logic [WORD_W-1:0] mem [NUM_OPS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_OPS; i++) mem[i] <= '0;
      end else if (we && (int'(wa) < NUM_OPS)) begin
         mem[wa] <= wd;
      end
   end

   always_comb begin
      rd1 = (int'(ra1) < NUM_OPS) ? mem[ra1] : '0;
      rd2 = (int'(ra2) < NUM_OPS) ? mem[ra2] : '0;
      rd3 = (int'(ra3) < NUM_OPS) ? mem[ra3] : '0;
   end

endmodule

// File: rtl/useq_arith_stub.sv
module useq_arith_stub
   import useq_pkg::*;
#(
   parameter int          WORD_W  = 16,
   parameter int unsigned MODULUS = 65521,
   parameter int          LAT     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  math_e             math,
   input  logic [WORD_W-1:0] opa,
   input  logic [WORD_W-1:0] opb,
   output logic              done,
   output logic [WORD_W-1:0] res
);

   localparam int LCW = (LAT > 1) ? $clog2(LAT) : 1;
   localparam logic [WORD_W:0]     MOD_S = (WORD_W+1)'(MODULUS);
   localparam logic [2*WORD_W-1:0] MOD_P = (2*WORD_W)'(MODULUS);

   generate
      if (LAT < 1) begin : g_bad_lat
         $error("useq_arith_stub: LAT must be at least 1");
      end
      if (MODULUS < 2 || (WORD_W < 32 && MODULUS >= (64'd1 << WORD_W))) begin : g_bad_mod
         $error("useq_arith_stub: MODULUS does not fit WORD_W");
      end
   endgenerate

   logic [WORD_W:0]       sum_w, dif_w;
   logic [2*WORD_W-1:0]   prod_w, prod_r;
   logic [WORD_W-1:0]     calc_w;
   logic [WORD_W-1:0]     res_q;

   always_comb begin
      sum_w = {1'b0, opa} + {1'b0, opb};
      if (sum_w >= MOD_S) sum_w = sum_w - MOD_S;
      if (opa >= opb) dif_w = {1'b0, opa} - {1'b0, opb};
      else            dif_w = {1'b0, opa} + MOD_S - {1'b0, opb};
      prod_w = (2*WORD_W)'(opa) * (2*WORD_W)'(opb);
      prod_r = prod_w % MOD_P;
      unique case (math)
         MATH_ADD: calc_w = sum_w[WORD_W-1:0];
         MATH_SUB: calc_w = dif_w[WORD_W-1:0];
         MATH_MUL: calc_w = prod_r[WORD_W-1:0];
         default:  calc_w = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   res_q <= '0;
      else if (req) res_q <= calc_w;
   end

   assign res = res_q;

   generate
      if (LAT == 1) begin : g_lat_one
         logic busy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) busy_q <= 1'b0;
            else        busy_q <= req;
         end
         assign done = busy_q;
      end else begin : g_lat_multi
         logic           busy_q;
         logic [LCW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy_q <= 1'b0;
               left_q <= '0;
            end else if (req) begin
               busy_q <= 1'b1;
               left_q <= LCW'(LAT - 1);
            end else if (busy_q) begin
               if (left_q == '0) busy_q <= 1'b0;
               else              left_q <= left_q - LCW'(1);
            end
         end
         assign done = busy_q && (left_q == '0);
      end
   endgenerate

   // R5
   res_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (int'(res) < int'(MODULUS)));

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
   import useq_pkg::*;
#(
   parameter int WORD_W     = 16,
   parameter int PROG_DEPTH = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  uinstr_t                       instr,
   input  logic [WORD_W-1:0]             opa,
   input  logic                          arith_done,
   input  logic [WORD_W-1:0]             arith_res,
   output logic [$clog2(PROG_DEPTH)-1:0] pc,
   output logic                          arith_req,
   output logic                          wr_en,
   output logic                          wr_bank,
   output logic [AW-1:0]                 wr_addr,
   output logic [WORD_W-1:0]             wr_data,
   output logic                          flag_r0z,
   output logic                          flag_r1z,
   output logic                          ready
);

   localparam int PCW = $clog2(PROG_DEPTH);
   localparam logic [AW-1:0] FLAG_ADDR [2] = '{ADDR_R0Z, ADDR_R1Z};

   generate
      if (PROG_DEPTH < 2 || (1 << PCW) != PROG_DEPTH) begin : g_bad_depth
         $error("useq_ctrl: PROG_DEPTH must be a power of two");
      end
   endgenerate

   seq_state_e      state_q;
   logic [PCW-1:0]  pc_q, loop_top_q;
   logic [CW-1:0]   loop_cnt_q;
   logic            odd_q;
   logic            ready_q;
   logic            pend_bank_q;
   logic [AW-1:0]   pend_addr_q;
   logic            zflag_q [2];

   logic run, cond_ok, calc_go, ztest_go, wait_done;

   always_comb begin
      run       = (state_q == ST_RUN) && !start;
      cond_ok   = (instr.opc == OPC_CALC)
               || ((instr.opc == OPC_CALC_ODD)  &&  odd_q)
               || ((instr.opc == OPC_CALC_EVEN) && !odd_q);
      calc_go   = run && cond_ok;
      ztest_go  = run && (instr.opc == OPC_ZTEST);
      wait_done = (state_q == ST_WAIT) && arith_done && !start;
   end

   assign arith_req = calc_go;

   always_comb begin
      wr_en   = 1'b0;
      wr_bank = 1'b0;
      wr_addr = '0;
      wr_data = '0;
      if (run && instr.opc == OPC_MOVE) begin
         wr_en   = 1'b1;
         wr_bank = ~instr.sb;
         wr_addr = instr.ad;
         wr_data = opa;
      end else if (wait_done) begin
         wr_en   = 1'b1;
         wr_bank = pend_bank_q;
         wr_addr = pend_addr_q;
         wr_data = arith_res;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         pc_q        <= '0;
         loop_top_q  <= '0;
         loop_cnt_q  <= '0;
         odd_q       <= 1'b0;
         ready_q     <= 1'b1;
         pend_bank_q <= 1'b0;
         pend_addr_q <= '0;
      end else if (start) begin
         state_q    <= ST_RUN;
         pc_q       <= '0;
         loop_top_q <= '0;
         loop_cnt_q <= '0;
         odd_q      <= 1'b0;
         ready_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_RUN: begin
               unique case (instr.opc)
                  OPC_HALT: begin
                     state_q <= ST_IDLE;
                     ready_q <= 1'b1;
                  end
                  OPC_MOVE, OPC_ZTEST: pc_q <= pc_q + PCW'(1);
                  OPC_CALC, OPC_CALC_ODD, OPC_CALC_EVEN: begin
                     if (cond_ok) begin
                        state_q     <= ST_WAIT;
                        pend_bank_q <= instr.db;
                        pend_addr_q <= instr.ad;
                     end else begin
                        pc_q <= pc_q + PCW'(1);
                     end
                  end
                  OPC_LOOP: begin
                     loop_cnt_q <= (instr.cnt == '0) ? '0 : instr.cnt - CW'(1);
                     loop_top_q <= pc_q + PCW'(1);
                     odd_q      <= 1'b0;
                     pc_q       <= pc_q + PCW'(1);
                  end
                  OPC_ENDLOOP: begin
                     if (loop_cnt_q != '0) begin
                        loop_cnt_q <= loop_cnt_q - CW'(1);
                        pc_q       <= loop_top_q;
                        odd_q      <= ~odd_q;
                     end else begin
                        pc_q <= pc_q + PCW'(1);
                     end
                  end
                  default: begin
                     state_q <= ST_IDLE;
                     ready_q <= 1'b1;
                  end
               endcase
            end
            ST_WAIT: begin
               if (arith_done) begin
                  state_q <= ST_RUN;
                  pc_q    <= pc_q + PCW'(1);
               end
            end
            default: ;
         endcase
      end
   end

   generate
      for (genvar g = 0; g < 2; g++) begin : g_zflag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               zflag_q[g] <= 1'b0;
            else if (ztest_go && instr.a1 == FLAG_ADDR[g])
               zflag_q[g] <= (opa == '0);
         end
      end
   endgenerate

   assign pc       = pc_q;
   assign ready    = ready_q;
   assign flag_r0z = zflag_q[0];
   assign flag_r1z = zflag_q[1];

   // R6
   calc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && !arith_done && !start) |=> (state_q == ST_WAIT && $stable(pc_q)));

   // R7
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(state_q == ST_RUN && instr.opc == OPC_ZTEST) |=> ($stable(flag_r0z) && $stable(flag_r1z)));

   // R8
   loop_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && !start && instr.opc == OPC_ENDLOOP && loop_cnt_q != '0)
      |=> (pc_q == $past(loop_top_q)));

   // R10
   skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && !start && instr.opc == OPC_CALC_ODD && !odd_q)
      |=> (state_q == ST_RUN && pc_q == $past(pc_q) + PCW'(1)));

   // R11
   halt_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && !start && instr.opc == OPC_HALT) |=> ready);

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !start) |=> (ready && $stable(pc_q)));

endmodule

// File: rtl/useq_top.sv
module useq_top
   import useq_pkg::*;
#(
   parameter int          WORD_W     = 16,
   parameter int unsigned MODULUS    = 65521,
   parameter int          ARITH_LAT  = 3,
   parameter int          PROG_DEPTH = 32,
   parameter int          NUM_OPS    = 38
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic                          prog_we,
   input  logic [$clog2(PROG_DEPTH)-1:0] prog_addr,
   input  logic [UI_W-1:0]               prog_data,
   input  logic                          host_we,
   input  logic                          host_bank,
   input  logic [AW-1:0]                 host_addr,
   input  logic [WORD_W-1:0]             host_wdata,
   output logic [WORD_W-1:0]             host_rdata,
   output logic                          ready,
   output logic                          flag_r0z,
   output logic                          flag_r1z
);

   localparam int PCW    = $clog2(PROG_DEPTH);
   localparam int NBANKS = 2;

   logic [UI_W-1:0]   rom [PROG_DEPTH];
   logic [PCW-1:0]    pc;
   uinstr_t           instr;
   logic [WORD_W-1:0] opa, opb;
   logic              arith_req, arith_done;
   logic [WORD_W-1:0] arith_res;
   logic              eng_we, eng_bank;
   logic [AW-1:0]     eng_addr;
   logic [WORD_W-1:0] eng_data;
   logic [WORD_W-1:0] bk_rd1 [NBANKS];
   logic [WORD_W-1:0] bk_rd2 [NBANKS];
   logic [WORD_W-1:0] bk_rd3 [NBANKS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < PROG_DEPTH; i++) rom[i] <= '0;
      end else if (prog_we) begin
         rom[prog_addr] <= prog_data;
      end
   end

   assign instr = uinstr_t'(rom[pc]);

   generate
      for (genvar b = 0; b < NBANKS; b++) begin : g_bank
         logic              sel_eng, sel_host;
         logic [AW-1:0]     wa;
         logic [WORD_W-1:0] wd;
         always_comb begin
            sel_eng  = eng_we && (eng_bank == 1'(b));
            sel_host = host_we && (host_bank == 1'(b)) && !sel_eng;
            wa       = sel_eng ? eng_addr : host_addr;
            wd       = sel_eng ? eng_data : host_wdata;
         end
         useq_bank #(
            .WORD_W (WORD_W),
            .NUM_OPS(NUM_OPS),
            .AW     (AW)
         ) u_bank (
            .clk  (clk),
            .rst_n(rst_n),
            .we   (sel_eng || sel_host),
            .wa   (wa),
            .wd   (wd),
            .ra1  (instr.a1),
            .ra2  (instr.a2),
            .ra3  (host_addr),
            .rd1  (bk_rd1[b]),
            .rd2  (bk_rd2[b]),
            .rd3  (bk_rd3[b])
         );
      end
   endgenerate

   assign opa        = bk_rd1[instr.sb];
   assign opb        = bk_rd2[instr.sb];
   assign host_rdata = bk_rd3[host_bank];

   useq_arith_stub #(
      .WORD_W (WORD_W),
      .MODULUS(MODULUS),
      .LAT    (ARITH_LAT)
   ) u_arith (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (arith_req),
      .math (instr.math),
      .opa  (opa),
      .opb  (opb),
      .done (arith_done),
      .res  (arith_res)
   );

   useq_ctrl #(
      .WORD_W    (WORD_W),
      .PROG_DEPTH(PROG_DEPTH)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .instr     (instr),
      .opa       (opa),
      .arith_done(arith_done),
      .arith_res (arith_res),
      .pc        (pc),
      .arith_req (arith_req),
      .wr_en     (eng_we),
      .wr_bank   (eng_bank),
      .wr_addr   (eng_addr),
      .wr_data   (eng_data),
      .flag_r0z  (flag_r0z),
      .flag_r1z  (flag_r1z),
      .ready     (ready)
   );

endmodule

// File: tb/useq_top_test.sv
`timescale 1ns/1ps
module useq_top_test;
   import useq_pkg::*;

   localparam int WORD_W = 16;
   localparam int MODV   = 65521;
   localparam int LAT    = 3;
   localparam int DEPTH  = 32;
   localparam int PCW    = 5;
   localparam int NVEC   = 10;

   // [33:32] math, [31:16] x, [15:0] y
   localparam logic [33:0] VECS [NVEC] = '{
      {2'd0, 16'd100,   16'd200},
      {2'd0, 16'd65520, 16'd1},
      {2'd0, 16'd65000, 16'd1000},
      {2'd0, 16'd0,     16'd0},
      {2'd1, 16'd500,   16'd200},
      {2'd1, 16'd200,   16'd500},
      {2'd1, 16'd7,     16'd7},
      {2'd2, 16'd3,     16'd5},
      {2'd2, 16'd65520, 16'd65520},
      {2'd2, 16'd1000,  16'd1000}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              prog_we = 1'b0;
   logic [PCW-1:0]    prog_addr = '0;
   logic [UI_W-1:0]   prog_data = '0;
   logic              host_we = 1'b0;
   logic              host_bank = 1'b0;
   logic [AW-1:0]     host_addr = '0;
   logic [WORD_W-1:0] host_wdata = '0;
   logic [WORD_W-1:0] host_rdata;
   logic              ready, flag_r0z, flag_r1z;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   useq_top uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
      .host_we(host_we), .host_bank(host_bank), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .ready(ready), .flag_r0z(flag_r0z), .flag_r1z(flag_r1z)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected<=150000", cyc);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(string tag, longint act, longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint ref_calc(int m, longint x, longint y);
      if (m == 0) return (x + y) % MODV;
      if (m == 1) return (x - y + MODV) % MODV;
      return (x * y) % MODV;
   endfunction

   function automatic uinstr_t mk(opc_e o, math_e m, bit sb, bit db,
                                  int a1, int a2, int ad, int cnt);
      uinstr_t u;
      u.opc  = o;
      u.math = m;
      u.sb   = sb;
      u.db   = db;
      u.a1   = AW'(a1);
      u.a2   = AW'(a2);
      u.ad   = AW'(ad);
      u.cnt  = CW'(cnt);
      return u;
   endfunction

   task automatic prog(int idx, uinstr_t ins);
      @(negedge clk);
      prog_we   = 1'b1;
      prog_addr = PCW'(idx);
      prog_data = ins;
      @(negedge clk);
      prog_we   = 1'b0;
   endtask

   task automatic hwrite(bit b, int a, int v);
      @(negedge clk);
      host_we    = 1'b1;
      host_bank  = b;
      host_addr  = AW'(a);
      host_wdata = WORD_W'(v);
      @(negedge clk);
      host_we    = 1'b0;
   endtask

   task automatic hread(bit b, int a, output longint v);
      @(negedge clk);
      host_bank = b;
      host_addr = AW'(a);
      #1;
      v = longint'(host_rdata);
   endtask

   // pulses start; n = edges after the start edge until ready is seen
   task automatic run_prog(output int n, output bit f0, output bit f1);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      f0 = flag_r0z;
      f1 = flag_r1z;
      n = 0;
      while (!ready && n < 2000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end
   endtask

   initial begin
      longint v;
      int     n;
      bit     f0, f1;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk("R2 ready after reset", ready, 1);
      chk("R2 flag_r0z after reset", flag_r0z, 0);
      chk("R2 flag_r1z after reset", flag_r1z, 0);
      hread(0, 0, v);  chk("R2 LO[0] after reset", v, 0);
      hread(1, 37, v); chk("R2 HI[37] after reset", v, 0);
      repeat (4) @(negedge clk);
      chk("R2 idle until start", ready, 1);

      // table of calc vectors: LO[5] op LO[6] -> HI[11]
      for (int i = 0; i < NVEC; i++) begin
         int m = int'(VECS[i][33:32]);
         int x = int'(VECS[i][31:16]);
         int y = int'(VECS[i][15:0]);
         hwrite(0, 5, x);
         hwrite(0, 6, y);
         prog(0, mk(OPC_CALC, math_e'(m), 0, 1, 5, 6, 11, 0));
         prog(1, mk(OPC_HALT, MATH_ADD, 0, 0, 0, 0, 0, 0));
         run_prog(n, f0, f1);
         hread(1, 11, v);
         chk("R1 R5 calc result", v, ref_calc(m, x, y));
         chk("R6 calc cycles", n, 1 + LAT + 1);
      end

      // same-bank calc: HI[12]*HI[13] -> HI[14], LO[14] untouched
      hwrite(1, 12, 7);
      hwrite(1, 13, 9);
      prog(0, mk(OPC_CALC, MATH_MUL, 1, 1, 12, 13, 14, 0));
      prog(1, mk(OPC_HALT, MATH_ADD, 0, 0, 0, 0, 0, 0));
      run_prog(n, f0, f1);
      hread(1, 14, v); chk("R6 same-bank result", v, 63);
      hread(0, 14, v); chk("R6 other bank untouched", v, 0);

      // move LO[3] -> HI[20], destination-bank bit says LO
      hwrite(0, 3, 16'h1234);
      hwrite(0, 20, 16'h5555);
      prog(0, mk(OPC_MOVE, MATH_ADD, 0, 0, 3, 0, 20, 0));
      prog(1, mk(OPC_HALT, MATH_ADD, 0, 0, 0, 0, 0, 0));
      run_prog(n, f0, f1);
      hread(1, 20, v); chk("R4 move to other bank", v, 16'h1234);
      hread(0, 20, v); chk("R4 source bank untouched", v, 16'h5555);
      chk("R4 move cycles", n, 2);

      // zero tests: set both flags
      hwrite(0, 7, 0);
      hwrite(1, 10, 0);
      prog(0, mk(OPC_ZTEST, MATH_ADD, 0, 0, 7, 0, 0, 0));
      prog(1, mk(OPC_ZTEST, MATH_ADD, 1, 0, 10, 0, 0, 0));
      prog(2, mk(OPC_HALT, MATH_ADD, 0, 0, 0, 0, 0, 0));
      run_prog(n, f0, f1);
      chk("R7 flag_r0z set", flag_r0z, 1);
      chk("R7 flag_r1z set", flag_r1z, 1);
      chk("R7 ztest cycles", n, 3);

      // clear R0-Z flag only; non-target address changes nothing
      hwrite(0, 7, 9);
      hwrite(0, 4, 0);
      prog(0, mk(OPC_ZTEST, MATH_ADD, 0, 0, 7, 0, 0, 0));
      prog(1, mk(OPC_ZTEST, MATH_ADD, 0, 0, 4, 0, 0, 0));
      prog(2, mk(OPC_HALT, MATH_ADD, 0, 0, 0, 0, 0, 0));
      run_prog(n, f0, f1);
      chk("R3 flag_r0z kept across start", f0, 1);
      chk("R3 flag_r1z kept across start", f1, 1);
      chk("R7 flag_r0z cleared", flag_r0z, 0);
      chk("R7 flag_r1z unchanged by other address", flag_r1z, 1);

      // counted loop N=5: LO[8] += LO[1]
      hwrite(0, 1, 1);
      hwrite(0, 8, 0);
      prog(0, mk(OPC_LOOP, MATH_ADD, 0, 0, 0, 0, 0, 5));
      prog(1, mk(OPC_CALC, MATH_ADD, 0, 0, 8, 1, 8, 0));
      prog(2, mk(OPC_ENDLOOP, MATH_ADD, 0, 0, 0, 0, 0, 0));
      prog(3, mk(OPC_HALT, MATH_ADD, 0, 0, 0, 0, 0, 0));
      run_prog(n, f0, f1);
      hread(0, 8, v); chk("R8 loop of 5 passes", v, 5);
      chk("R8 loop cycles", n, 1 + 5 * (LAT + 2) + 1);

      // count 0 runs once
      hwrite(0, 8, 0);
      prog(0, mk(OPC_LOOP, MATH_ADD, 0, 0, 0, 0, 0, 0));
      run_prog(n, f0, f1);
      hread(0, 8, v); chk("R8 count zero runs once", v, 1);
      chk("R8 count zero cycles", n, 1 + (LAT + 2) + 1);

      // parity: N=5, odd passes count in LO[8], even in LO[9]
      hwrite(0, 8, 0);
      hwrite(0, 9, 0);
      prog(0, mk(OPC_LOOP, MATH_ADD, 0, 0, 0, 0, 0, 5));
      prog(1, mk(OPC_CALC_ODD, MATH_ADD, 0, 0, 8, 1, 8, 0));
      prog(2, mk(OPC_CALC_EVEN, MATH_ADD, 0, 0, 9, 1, 9, 0));
      prog(3, mk(OPC_ENDLOOP, MATH_ADD, 0, 0, 0, 0, 0, 0));
      prog(4, mk(OPC_HALT, MATH_ADD, 0, 0, 0, 0, 0, 0));
      run_prog(n, f0, f1);
      hread(0, 8, v); chk("R9 odd passes executed", v, 2);
      hread(0, 9, v); chk("R9 even passes executed", v, 3);
      chk("R10 parity loop cycles", n, 1 + 5 * ((LAT + 1) + 1 + 1) + 1);

      // outside a loop the pass is even
      hwrite(0, 8, 0);
      hwrite(0, 9, 0);
      prog(0, mk(OPC_CALC_ODD, MATH_ADD, 0, 0, 8, 1, 8, 0));
      prog(1, mk(OPC_CALC_EVEN, MATH_ADD, 0, 0, 9, 1, 9, 0));
      prog(2, mk(OPC_HALT, MATH_ADD, 0, 0, 0, 0, 0, 0));
      run_prog(n, f0, f1);
      hread(0, 8, v); chk("R10 skipped calc writes nothing", v, 0);
      hread(0, 9, v); chk("R9 even calc outside loop", v, 1);
      chk("R10 skip costs one cycle", n, 1 + (LAT + 1) + 1);

      // halt with odd parity left inside a loop, then restart
      prog(0, mk(OPC_LOOP, MATH_ADD, 0, 0, 0, 0, 0, 2));
      prog(1, mk(OPC_ENDLOOP, MATH_ADD, 0, 0, 0, 0, 0, 0));
      prog(2, mk(OPC_HALT, MATH_ADD, 0, 0, 0, 0, 0, 0));
      run_prog(n, f0, f1);
      chk("R8 empty loop cycles", n, 4);
      repeat (3) @(negedge clk);
      chk("R11 ready held after halt", ready, 1);
      hwrite(0, 8, 0);
      prog(0, mk(OPC_CALC_ODD, MATH_ADD, 0, 0, 8, 1, 8, 0));
      prog(1, mk(OPC_HALT, MATH_ADD, 0, 0, 0, 0, 0, 0));
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R3 ready low after start", ready, 0);
      n = 0;
      while (!ready && n < 2000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
      end
      hread(0, 8, v); chk("R3 start clears parity", v, 0);
      chk("R11 halt raises ready", n, 2);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule